// File: doc/BRIEF.md
# Two-Wire Digital Potentiometer Command Front End

This block is the slave side of a two-wire serial bus (a clock line and a bidirectional data line) for a digital potentiometer. It watches the bus for START and STOP conditions, accepts an identification byte addressed to this device, and captures an instruction byte. The instruction byte carries an opcode, a register index and a bank index. Depending on the opcode, the block then reads one more byte from the host, returns one byte to the host, or finishes at once. Instead of a transaction it can also enter a continuous stepping mode that nudges the wiper up or down once per clock pulse.

The block holds no potentiometer registers of its own. It hands a decoded command stream to a separate register core. That stream is a one-cycle command pulse with opcode, register, bank and write-data fields, plus single-cycle step-up and step-down pulses. For read commands the core answers on `rd_data`, and the block shifts that value back onto the bus. The data line is driven open-drain: while `sda_oe` is high the pad pulls the line low.

Top module: `pot_serial_front`

## Requirements
- R1: A START is the data line falling while the clock line is high. A STOP is the data line rising while the clock line is high. A STOP returns the block to idle with `sda_oe` low and no command issued for a partial byte. A START outside stepping mode restarts identification-byte parsing.
- R2: The identification byte is received MSB first. Bits 7..4 must equal DEV_TYPE (default 0101), bit 3 must be 0, and bits 2..0 must equal `strap_addr`. On a match the block acknowledges by holding `sda_oe` high for the ninth clock.
- R3: If the identification byte does not match, the block gives no acknowledge and issues no command. It ignores every later bit until the next START.
- R4: The instruction byte holds the opcode in bits 7..4, the register index in bits 3..2 and the bank index in bits 1..0. These appear on `cmd_op`, `cmd_reg` and `cmd_bank`.
- R5: Opcode 1011 (read data register) and 1100 (write data register) are accepted for any bank. Opcodes 1001 (read wiper), 1010 (write wiper), 1101 (data register to wiper), 1110 (wiper to data register) and 0010 (step mode) are accepted only with bank 00. Any other opcode or bank is rejected: it gets no acknowledge and no command.
- R6: For the write opcodes 1010 and 1100, the third byte is acknowledged. After its eighth bit, `cmd_valid` pulses and the byte appears on `cmd_wdata`.
- R7: For the transfer opcodes 1101 and 1110, `cmd_valid` pulses after the instruction byte. Any further byte before STOP is not acknowledged and issues nothing.
- R8: For the read opcodes 1001 and 1011, `cmd_valid` pulses after the instruction byte. `rd_data` is sampled when the acknowledge clock ends and is shifted out MSB first. `sda_oe` changes only while the clock line is low.
- R9: After an accepted 0010 instruction, every clock-line rise gives one pulse. The pulse is on `step_up` if the data line is high and on `step_dn` if it is low. This includes the rises that precede a START or STOP pattern.
- R10: Stepping mode ignores START and is left only by a STOP. After that STOP, clock pulses produce no steps.
- R11: `cmd_valid`, `step_up` and `step_dn` are single-cycle pulses, and `step_up` and `step_dn` never pulse together.
- R12: During and right after reset, `sda_oe`, `cmd_valid`, the step pulses and all command fields are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_addr | input | 3 | Slave address straps |
| rd_data | input | 8 | Read value from the register core for the current command |
| sda_oe | output | 1 | High pulls the data line low |
| cmd_valid | output | 1 | One-cycle command issue pulse |
| cmd_op | output | 4 | Opcode of the current command |
| cmd_reg | output | 2 | Register index |
| cmd_bank | output | 2 | Bank index |
| cmd_wdata | output | 8 | Write data for write commands |
| step_up | output | 1 | One-cycle wiper step toward the high end |
| step_dn | output | 1 | One-cycle wiper step toward the low end |

## Verification
The bench builds the block with the default DEV_TYPE of 0101 and a two-stage synchronizer. It runs the bus at ten system clocks per half bit, which leaves enough margin for the three-cycle edge latency before each acknowledge or read bit must be valid. With the straps tied to 101, the address, type and reserved-bit mismatches are all reachable. The bench's register-core model derives `rd_data` from the latched command fields, so every read can be predicted from the instruction byte alone.

// File: rtl/pot_fe_pkg.sv
// Shared constants and types for the two-wire potentiometer front end.
// Assumes 8-bit bus bytes and a 3-bit strap address field.
package pot_fe_pkg;
    localparam int BYTE_W    = 8;
    localparam int ID_ADDR_W = 3;
    localparam int CNT_W     = $clog2(BYTE_W + 1);

    localparam logic [3:0] OPC_RD_WCR = 4'b1001;
    localparam logic [3:0] OPC_WR_WCR = 4'b1010;
    localparam logic [3:0] OPC_RD_DR  = 4'b1011;
    localparam logic [3:0] OPC_WR_DR  = 4'b1100;
    localparam logic [3:0] OPC_DR2WCR = 4'b1101;
    localparam logic [3:0] OPC_WCR2DR = 4'b1110;
    localparam logic [3:0] OPC_STEP   = 4'b0010;

    typedef enum logic [1:0] {K_READ, K_WRITE, K_XFER, K_STEP} cmd_kind_t;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ID, ST_ID_ACK, ST_INS, ST_INS_ACK,
        ST_WDAT, ST_WDAT_ACK, ST_RDAT, ST_STEP, ST_DONE
    } fe_state_t;
endpackage

// File: rtl/pot_line_sync.sv
// Synchronizes a group of asynchronous lines into clk and keeps one extra
// history stage per line for edge detection.
// Assumes idle-high lines, so reset fills every stage with ones.
module pot_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] lvl,
    output logic [LINES-1:0] lvl_d
);
    localparam int DEPTH = STAGES + 1;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [DEPTH-1:0] chain;

        // Shift the raw line through the synchronizer and history stage.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[DEPTH-2:0], din[g]};
        end

        assign lvl[g]   = chain[DEPTH-2];
        assign lvl_d[g] = chain[DEPTH-1];
    end
endmodule

// File: rtl/pot_cmd_check.sv
// Classifies an instruction opcode and checks it against the bank rule:
// commands that touch the wiper register need bank 00.
// Purely combinational; assumes the caller samples it only on a full byte.
module pot_cmd_check
    import pot_fe_pkg::*;
(
    input  logic [3:0] opc,
    input  logic [1:0] bank,
    output logic       accept,
    output cmd_kind_t  kind
);
    logic bank_zero;
    assign bank_zero = (bank == 2'b00);

    // Map opcode to a command class and a legality flag.
    always_comb begin
        kind   = K_XFER;
        accept = 1'b0;
        case (opc)
            OPC_RD_WCR: begin kind = K_READ;  accept = bank_zero; end
            OPC_RD_DR:  begin kind = K_READ;  accept = 1'b1;      end
            OPC_WR_WCR: begin kind = K_WRITE; accept = bank_zero; end
            OPC_WR_DR:  begin kind = K_WRITE; accept = 1'b1;      end
            OPC_DR2WCR,
            OPC_WCR2DR: begin kind = K_XFER;  accept = bank_zero; end
            OPC_STEP:   begin kind = K_STEP;  accept = bank_zero; end
            default:    begin kind = K_XFER;  accept = 1'b0;      end
        endcase
    end
endmodule

// File: rtl/pot_step_gen.sv
// Turns clock-line rises into single-cycle wiper step pulses while the
// stepping mode is active. The data line level selects the direction.
module pot_step_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic scl_rise,
    input  logic sda_lvl,
    output logic step_up,
    output logic step_dn
);
    // Register one pulse per qualified rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_up <= 1'b0;
            step_dn <= 1'b0;
        end else begin
            step_up <= active & scl_rise & sda_lvl;
            step_dn <= active & scl_rise & ~sda_lvl;
        end
    end
endmodule

// File: rtl/pot_serial_front.sv
// Slave-side two-wire front end for a digital potentiometer. It parses the
// identification and instruction bytes, runs write/read/transfer
// transactions or the stepping mode, drives acknowledge and read bits
// open-drain, and issues decoded commands to an external register core.
// Assumes the bus clock half period spans several system clocks.
module pot_serial_front
    import pot_fe_pkg::*;
#(
    parameter logic [3:0] DEV_TYPE    = 4'b0101,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    input  logic [ID_ADDR_W-1:0] strap_addr,
    input  logic [BYTE_W-1:0]    rd_data,
    output logic                 sda_oe,
    output logic                 cmd_valid,
    output logic [3:0]           cmd_op,
    output logic [1:0]           cmd_reg,
    output logic [1:0]           cmd_bank,
    output logic [BYTE_W-1:0]    cmd_wdata,
    output logic                 step_up,
    output logic                 step_dn
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    logic [1:0] lv, lv_d;
    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, start_evt, stop_evt;

    fe_state_t         state;
    cmd_kind_t         kind_q, kind_c;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] sh;
    logic              accept_c, id_ok, full;

    pot_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({sda_i, scl_i}),
        .lvl   (lv),
        .lvl_d (lv_d)
    );

    assign scl_s     = lv[0];
    assign sda_s     = lv[1];
    assign scl_rise  = scl_s & ~lv_d[0];
    assign scl_fall  = ~scl_s & lv_d[0];
    assign start_evt = scl_s & lv_d[0] & ~sda_s & lv_d[1];
    assign stop_evt  = scl_s & lv_d[0] & sda_s & ~lv_d[1];
    assign full      = (bit_cnt == FULL);

    assign id_ok = (sh[7:4] == DEV_TYPE) && !sh[3] && (sh[2:0] == strap_addr);

    pot_cmd_check u_check (
        .opc    (sh[7:4]),
        .bank   (sh[1:0]),
        .accept (accept_c),
        .kind   (kind_c)
    );

    pot_step_gen u_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (state == ST_STEP),
        .scl_rise (scl_rise),
        .sda_lvl  (sda_s),
        .step_up  (step_up),
        .step_dn  (step_dn)
    );

    // Transaction sequencer: bit capture, acknowledge, read shift, command issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            kind_q    <= K_XFER;
            bit_cnt   <= '0;
            sh        <= '0;
            sda_oe    <= 1'b0;
            cmd_valid <= 1'b0;
            cmd_op    <= '0;
            cmd_reg   <= '0;
            cmd_bank  <= '0;
            cmd_wdata <= '0;
        end else begin
            cmd_valid <= 1'b0;
            if (stop_evt) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (start_evt && state != ST_STEP) begin
                state   <= ST_ID;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else begin
                case (state)
                    ST_ID: begin
                        if (scl_rise && !full) begin
                            sh      <= {sh[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && full) begin
                            bit_cnt <= '0;
                            if (id_ok) begin
                                sda_oe <= 1'b1;
                                state  <= ST_ID_ACK;
                            end else begin
                                state  <= ST_DONE;
                            end
                        end
                    end
                    ST_ID_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_INS;
                        end
                    end
                    ST_INS: begin
                        if (scl_rise && !full) begin
                            sh      <= {sh[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && full) begin
                            bit_cnt <= '0;
                            if (accept_c) begin
                                sda_oe    <= 1'b1;
                                state     <= ST_INS_ACK;
                                kind_q    <= kind_c;
                                cmd_op    <= sh[7:4];
                                cmd_reg   <= sh[3:2];
                                cmd_bank  <= sh[1:0];
                                cmd_valid <= (kind_c == K_READ) || (kind_c == K_XFER);
                            end else begin
                                state <= ST_DONE;
                            end
                        end
                    end
                    ST_INS_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            case (kind_q)
                                K_READ: begin
                                    sh     <= rd_data;
                                    sda_oe <= ~rd_data[BYTE_W-1];
                                    state  <= ST_RDAT;
                                end
                                K_WRITE: begin
                                    sda_oe <= 1'b0;
                                    state  <= ST_WDAT;
                                end
                                K_STEP: begin
                                    sda_oe <= 1'b0;
                                    state  <= ST_STEP;
                                end
                                default: begin
                                    sda_oe <= 1'b0;
                                    state  <= ST_DONE;
                                end
                            endcase
                        end
                    end
                    ST_WDAT: begin
                        if (scl_rise && !full) begin
                            sh      <= {sh[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && full) begin
                            bit_cnt   <= '0;
                            cmd_wdata <= sh;
                            cmd_valid <= 1'b1;
                            sda_oe    <= 1'b1;
                            state     <= ST_WDAT_ACK;
                        end
                    end
                    ST_WDAT_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_DONE;
                        end
                    end
                    ST_RDAT: begin
                        if (scl_rise && !full) begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (full) begin
                                sda_oe <= 1'b0;
                                state  <= ST_DONE;
                            end else begin
                                sh     <= sh << 1;
                                sda_oe <= ~sh[BYTE_W-2];
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/pot_serial_front_chk.sv
// Property checker for pot_serial_front, attached by bind.
module pot_serial_front_chk
    import pot_fe_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       stop_evt,
    input logic       sda_oe,
    input logic       cmd_valid,
    input logic [3:0] cmd_op,
    input logic [1:0] cmd_bank,
    input logic       step_up,
    input logic       step_dn
);
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s); // R8
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe); // R1
    AST_WCR_BANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == OPC_RD_WCR || cmd_op == OPC_WR_WCR ||
                       cmd_op == OPC_DR2WCR || cmd_op == OPC_WCR2DR)) |-> (cmd_bank == 2'b00)); // R5
    AST_CMD_KNOWN_OP: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_op[3] && cmd_op != 4'b1000 && cmd_op != 4'b1111)); // R4
    AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid); // R11
    AST_STEP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_up && step_dn)); // R11
    AST_STEP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up || step_dn) |=> !(step_up || step_dn)); // R9
endmodule

bind pot_serial_front pot_serial_front_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .stop_evt  (stop_evt),
    .sda_oe    (sda_oe),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_bank  (cmd_bank),
    .step_up   (step_up),
    .step_dn   (step_dn)
);

// File: tb/pot_serial_front_tb.sv
module pot_serial_front_tb;
    localparam int H = 10;
    localparam int NV = 13;
    // {id, instruction, data, expect id ack, expect instruction ack}
    localparam logic [25:0] VEC [0:NV-1] = '{
        {8'h55, 8'hA0, 8'h3C, 1'b1, 1'b1},
        {8'h55, 8'hC7, 8'h81, 1'b1, 1'b1},
        {8'h55, 8'h90, 8'h00, 1'b1, 1'b1},
        {8'h55, 8'hBE, 8'h00, 1'b1, 1'b1},
        {8'h55, 8'hD8, 8'h77, 1'b1, 1'b1},
        {8'h55, 8'hE4, 8'h12, 1'b1, 1'b1},
        {8'h55, 8'hA1, 8'h44, 1'b1, 1'b0},
        {8'h55, 8'hD2, 8'h44, 1'b1, 1'b0},
        {8'h55, 8'h70, 8'h44, 1'b1, 1'b0},
        {8'h55, 8'h21, 8'h44, 1'b1, 1'b0},
        {8'h54, 8'hA0, 8'h44, 1'b0, 1'b0},
        {8'h5D, 8'hA0, 8'h44, 1'b0, 1'b0},
        {8'h75, 8'hA0, 8'h44, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'b101;
    logic       sda_line;
    logic [7:0] rd_data;
    logic       sda_oe, cmd_valid, step_up, step_dn;
    logic [3:0] cmd_op;
    logic [1:0] cmd_reg, cmd_bank;
    logic [7:0] cmd_wdata;

    assign sda_line = sda_m & ~sda_oe;
    assign rd_data  = {cmd_op, cmd_reg, cmd_bank} ^ 8'h3C;

    pot_serial_front u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .strap_addr (strap),
        .rd_data    (rd_data),
        .sda_oe     (sda_oe),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_reg    (cmd_reg),
        .cmd_bank   (cmd_bank),
        .cmd_wdata  (cmd_wdata),
        .step_up    (step_up),
        .step_dn    (step_dn)
    );

    int n_chk = 0, n_bad = 0;
    int cmd_cnt = 0, up_cnt = 0, dn_cnt = 0;
    logic [7:0] last_ins = '0, last_wd = '0;
    bit done = 1'b0;

    always @(negedge clk) begin
        if (cmd_valid) begin
            cmd_cnt++;
            last_ins = {cmd_op, cmd_reg, cmd_bank};
            last_wd  = cmd_wdata;
        end
        if (step_up) up_cnt++;
        if (step_dn) dn_cnt++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hold(H);
        scl_m = 1'b1; hold(H);
        sda_m = 1'b0; hold(H);
        scl_m = 1'b0; hold(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold(H);
        scl_m = 1'b1; hold(H);
        sda_m = 1'b1; hold(H);
    endtask

    task automatic bus_bit(input logic b, output logic r);
        sda_m = b; hold(H);
        scl_m = 1'b1; hold(H / 2);
        r = sda_line; hold(H / 2);
        scl_m = 1'b0; hold(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], r);
        bus_bit(1'b1, r);
        ack = ~r;
    endtask

    task automatic read_byte(output logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, r);
            v[i] = r;
        end
        bus_bit(1'b1, r);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic a, r;
        logic [7:0] v;
        int base, u0, d0;
        hold(5);
        chk("R12 sda_oe in reset", sda_oe, 0);
        rst_n = 1'b1;
        hold(3);
        chk("R12 sda_oe after reset", sda_oe, 0);
        chk("R12 cmd_valid after reset", cmd_valid, 0);
        chk("R12 steps after reset", {step_up, step_dn}, 0);
        chk("R12 fields after reset", {cmd_op, cmd_reg, cmd_bank, cmd_wdata}, 0);

        for (int i = 0; i < NV; i++) begin
            logic [7:0] id, ins, dat;
            logic ida, insa;
            {id, ins, dat, ida, insa} = VEC[i];
            bus_start();
            send_byte(id, a);
            chk("R2 id ack", a, ida);
            base = cmd_cnt;
            send_byte(ins, a);
            if (!ida) begin
                chk("R3 no ack after id mismatch", a, 0);
                chk("R3 no command after id mismatch", cmd_cnt - base, 0);
            end else begin
                chk("R5 instruction ack", a, insa);
                if (!insa) begin
                    chk("R5 rejected command not issued", cmd_cnt - base, 0);
                end else begin
                    case (ins[7:4])
                        4'hA, 4'hC: begin
                            send_byte(dat, a);
                            chk("R6 data byte ack", a, 1);
                            chk("R6 one command", cmd_cnt - base, 1);
                            chk("R6 write data", last_wd, dat);
                            chk("R4 fields on write", last_ins, ins);
                        end
                        4'h9, 4'hB: begin
                            read_byte(v);
                            chk("R8 read byte", v, ins ^ 8'h3C);
                            chk("R8 one command", cmd_cnt - base, 1);
                            chk("R4 fields on read", last_ins, ins);
                        end
                        default: begin
                            chk("R7 transfer issued", cmd_cnt - base, 1);
                            chk("R4 fields on transfer", last_ins, ins);
                            send_byte(dat, a);
                            chk("R7 extra byte not acked", a, 0);
                            chk("R7 no extra command", cmd_cnt - base, 1);
                        end
                    endcase
                end
            end
            bus_stop();
        end

        // STOP in the middle of a data byte aborts the write
        bus_start();
        send_byte(8'h55, a);
        send_byte(8'hC4, a);
        base = cmd_cnt;
        for (int k = 0; k < 4; k++) bus_bit(1'b0, r);
        bus_stop();
        chk("R1 stop aborts partial write", cmd_cnt - base, 0);
        chk("R1 stop releases line", sda_oe, 0);

        // repeated START mid-byte restarts at the identification byte
        bus_start();
        send_byte(8'h55, a);
        send_byte(8'hC4, a);
        for (int k = 0; k < 3; k++) bus_bit(1'b1, r);
        bus_start();
        base = cmd_cnt;
        send_byte(8'h55, a);
        chk("R1 restart id ack", a, 1);
        send_byte(8'hA0, a);
        send_byte(8'h5A, a);
        chk("R1 restart write issued", cmd_cnt - base, 1);
        chk("R1 restart write data", last_wd, 8'h5A);
        bus_stop();

        // stepping mode
        bus_start();
        send_byte(8'h55, a);
        send_byte(8'h20, a);
        chk("R9 step instruction ack", a, 1);
        u0 = up_cnt;
        d0 = dn_cnt;
        for (int k = 0; k < 3; k++) bus_bit(1'b1, r);
        for (int k = 0; k < 2; k++) bus_bit(1'b0, r);
        hold(4);
        chk("R9 R11 up steps", up_cnt - u0, 3);
        chk("R9 R11 down steps", dn_cnt - d0, 2);
        bus_start();
        bus_bit(1'b0, r);
        hold(4);
        chk("R10 start ignored up", up_cnt - u0, 4);
        chk("R10 start ignored down", dn_cnt - d0, 3);
        bus_stop();
        bus_bit(1'b1, r);
        bus_bit(1'b0, r);
        hold(4);
        chk("R10 no steps after stop up", up_cnt - u0, 4);
        chk("R10 no steps after stop down", dn_cnt - d0, 4);
        bus_stop();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule